// File: doc/BRIEF.md
# Synchronous Offset Gross Error Detector

This block watches the request/acknowledge handshake of a parallel SCSI bus during synchronous data phases. It keeps a running count of the requests that have not yet been acknowledged, which is the outstanding offset. It compares that count, and the occupancy of the data FIFO beside it, against the rules agreed for the transfer. When a rule is broken, it raises a sticky gross-error flag and a code naming the violation.

Five violations are detected:

- a FIFO write while the FIFO is full;
- an acknowledge with nothing outstanding while acting as target;
- a request that would take the offset past the programmed maximum;
- a bus phase change with offset still outstanding while acting as initiator;
- the start of any transfer other than a synchronous receive while the FIFO still holds data.

A programmed maximum of zero selects asynchronous operation. In that mode the three offset checks are switched off.

All inputs are synchronous to one clock, and every strobe is one cycle wide. The surrounding bus logic feeds the pulses in. It reads `errFlag` and `errCause` and pulses `clearErr` once the error has been handled.

Top module: `sync_offset_guard`

## Requirements
- R1: `offsetCount` rises by one after a cycle with `reqPulse` alone and falls by one after a cycle with `ackPulse` alone. It is unchanged after a cycle with both or neither. The new value appears on the clock edge that samples the strobes.
- R2: The offset count saturates. An acknowledge at zero leaves it at zero, and a request at the all-ones value leaves it at all-ones.
- R3: `fifoWrite` while `fifoLevel` equals FIFO_DEPTH is a data-overflow violation, cause code 1. This check applies in both roles and in asynchronous mode.
- R4: With `isTarget`=1, an `ackPulse` without `reqPulse` while `offsetCount` is zero is an offset-underflow violation, cause code 2. With `isTarget`=0 the same event is not a violation.
- R5: A `reqPulse` without `ackPulse` while `offsetCount` is already at or above `maxOffset` is an offset-overflow violation, cause code 3. This check applies in either role.
- R6: With `isTarget`=0, `phaseChange` while `offsetCount` is nonzero is a phase violation, cause code 4. With `isTarget`=1 it is not a violation.
- R7: `xferStart` with `xferType` other than 2'b00 (synchronous receive) while `fifoLevel` is nonzero is a residual-data violation, cause code 5.
- R8: While `maxOffset` is zero, the checks of R4, R5 and R6 never fire, and `offsetCount` is forced to zero on the next edge.
- R9: A violation sets `errFlag` and `errCause` on the next edge. When several violations occur in one cycle, the lowest cause code is kept. Later violations leave the flag and the code unchanged until a clear.
- R10: `clearErr` returns `errFlag` and `errCause` to 0 on the next edge. If a violation occurs in that same cycle, its code is captured instead.
- R11: After reset, `offsetCount`, `errFlag` and `errCause` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| isTarget | input | 1 | 1 = target role, 0 = initiator role |
| reqPulse | input | 1 | One-cycle strobe per REQ pulse |
| ackPulse | input | 1 | One-cycle strobe per ACK pulse |
| phaseChange | input | 1 | One-cycle strobe on a bus phase change |
| maxOffset | input | OFFSET_W | Negotiated maximum offset; 0 = asynchronous |
| fifoWrite | input | 1 | One-cycle strobe per FIFO write attempt |
| fifoLevel | input | LEVEL_W | Current FIFO occupancy, 0 to FIFO_DEPTH |
| xferStart | input | 1 | One-cycle strobe when a transfer starts |
| xferType | input | 2 | Kind of transfer started; 2'b00 = synchronous receive |
| clearErr | input | 1 | One-cycle strobe that clears the error |
| errFlag | output | 1 | Sticky gross-error flag |
| errCause | output | 3 | Code of the first violation, 0 when clear |
| offsetCount | output | OFFSET_W | Outstanding offset count |

## Verification
The bench builds the block with OFFSET_W=4 and FIFO_DEPTH=8. A 4-bit count reaches its all-ones ceiling of 15 within a few requests, which exercises the upper saturation of R2. A maximum offset of 15 then makes the overflow check and the saturation meet in the same cycle. A depth of 8 lets random FIFO levels land on both the full and the empty boundary often. Random traffic over both roles, including cycles that combine several violations and clears, shows the priority and capture rules at work.

// File: rtl/soed_pkg.sv
package soed_pkg;

  typedef enum logic [2:0] {
    CAUSE_NONE      = 3'd0,
    CAUSE_FIFO_OVF  = 3'd1,
    CAUSE_OFS_UNDER = 3'd2,
    CAUSE_OFS_OVER  = 3'd3,
    CAUSE_PHASE     = 3'd4,
    CAUSE_RESIDUAL  = 3'd5
  } cause_e;

  localparam int NUM_CAUSES = 5;

  localparam logic [1:0] XFER_SYNC_RX = 2'b00;

  // Strobes from control to datapath.
  typedef struct packed {
    logic   cntUp;
    logic   cntDown;
    logic   cntClear;
    logic   violate;
    cause_e cause;
  } ctrl_s;

endpackage

// File: rtl/soed_ctrl.sv
module soed_ctrl
  import soed_pkg::*;
#(
  parameter int OFFSET_W   = 5,
  parameter int FIFO_DEPTH = 16,
  parameter int LEVEL_W    = $clog2(FIFO_DEPTH + 1)
) (
  input  logic                isTarget,
  input  logic                reqPulse,
  input  logic                ackPulse,
  input  logic                phaseChange,
  input  logic [OFFSET_W-1:0] maxOffset,
  input  logic                fifoWrite,
  input  logic [LEVEL_W-1:0]  fifoLevel,
  input  logic                xferStart,
  input  logic [1:0]          xferType,
  input  logic [OFFSET_W-1:0] offsetCount,
  output ctrl_s               ctrl
);

  localparam logic [OFFSET_W-1:0] CNT_TOP  = '1;
  localparam logic [LEVEL_W-1:0]  LVL_FULL = LEVEL_W'(FIFO_DEPTH);

  logic syncMode;
  logic upOnly;
  logic downOnly;
  logic cntIsZero;
  logic [NUM_CAUSES:1] viol;

  assign syncMode  = |maxOffset;
  assign upOnly    = reqPulse & ~ackPulse;
  assign downOnly  = ackPulse & ~reqPulse;
  assign cntIsZero = (offsetCount == '0);

  // Violation detectors, indexed by cause code.
  always_comb begin
    viol[CAUSE_FIFO_OVF]  = fifoWrite & (fifoLevel == LVL_FULL);
    viol[CAUSE_OFS_UNDER] = syncMode & isTarget & downOnly & cntIsZero;
    viol[CAUSE_OFS_OVER]  = syncMode & upOnly & (offsetCount >= maxOffset);
    viol[CAUSE_PHASE]     = syncMode & ~isTarget & phaseChange & ~cntIsZero;
    viol[CAUSE_RESIDUAL]  = xferStart & (xferType != XFER_SYNC_RX) &
                            (fifoLevel != '0);
  end

  // The lowest code wins, so scan from the highest down.
  cause_e pickCause;
  always_comb begin
    pickCause = CAUSE_NONE;
    for (int i = NUM_CAUSES; i >= 1; i--) begin
      if (viol[i]) pickCause = cause_e'(3'(i));
    end
  end

  always_comb begin
    ctrl.cntClear = ~syncMode;
    ctrl.cntUp    = syncMode & upOnly & (offsetCount != CNT_TOP);
    ctrl.cntDown  = syncMode & downOnly & ~cntIsZero;
    ctrl.violate  = |viol;
    ctrl.cause    = pickCause;
  end

endmodule

// File: rtl/soed_datapath.sv
module soed_datapath
  import soed_pkg::*;
#(
  parameter int OFFSET_W = 5
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrl_s               ctrl,
  input  logic                clearErr,
  output logic [OFFSET_W-1:0] offsetCount,
  output logic                errFlag,
  output logic [2:0]          errCause
);

  logic [OFFSET_W-1:0] cntQ;
  logic                flagQ;
  cause_e              causeQ;

  always_ff @(posedge clk) begin
    if (!rstN)              cntQ <= '0;
    else if (ctrl.cntClear) cntQ <= '0;
    else if (ctrl.cntUp)    cntQ <= cntQ + 1'b1;
    else if (ctrl.cntDown)  cntQ <= cntQ - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flagQ  <= 1'b0;
      causeQ <= CAUSE_NONE;
    end else if (ctrl.violate && (!flagQ || clearErr)) begin
      flagQ  <= 1'b1;
      causeQ <= ctrl.cause;
    end else if (clearErr) begin
      flagQ  <= 1'b0;
      causeQ <= CAUSE_NONE;
    end
  end

  assign offsetCount = cntQ;
  assign errFlag     = flagQ;
  assign errCause    = causeQ;

endmodule

// File: rtl/sync_offset_guard.sv
module sync_offset_guard
  import soed_pkg::*;
#(
  parameter int OFFSET_W   = 5,
  parameter int FIFO_DEPTH = 16,
  parameter int LEVEL_W    = $clog2(FIFO_DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                isTarget,
  input  logic                reqPulse,
  input  logic                ackPulse,
  input  logic                phaseChange,
  input  logic [OFFSET_W-1:0] maxOffset,
  input  logic                fifoWrite,
  input  logic [LEVEL_W-1:0]  fifoLevel,
  input  logic                xferStart,
  input  logic [1:0]          xferType,
  input  logic                clearErr,
  output logic                errFlag,
  output logic [2:0]          errCause,
  output logic [OFFSET_W-1:0] offsetCount
);

  ctrl_s ctrlBus;

  soed_ctrl #(
    .OFFSET_W  (OFFSET_W),
    .FIFO_DEPTH(FIFO_DEPTH),
    .LEVEL_W   (LEVEL_W)
  ) ctrl_i (
    .isTarget   (isTarget),
    .reqPulse   (reqPulse),
    .ackPulse   (ackPulse),
    .phaseChange(phaseChange),
    .maxOffset  (maxOffset),
    .fifoWrite  (fifoWrite),
    .fifoLevel  (fifoLevel),
    .xferStart  (xferStart),
    .xferType   (xferType),
    .offsetCount(offsetCount),
    .ctrl       (ctrlBus)
  );

  soed_datapath #(
    .OFFSET_W(OFFSET_W)
  ) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .ctrl       (ctrlBus),
    .clearErr   (clearErr),
    .offsetCount(offsetCount),
    .errFlag    (errFlag),
    .errCause   (errCause)
  );

endmodule

// File: rtl/soed_checker.sv
module soed_checker #(
  parameter int OFFSET_W   = 5,
  parameter int FIFO_DEPTH = 16,
  parameter int LEVEL_W    = $clog2(FIFO_DEPTH + 1)
) (
  input logic                clk,
  input logic                rstN,
  input logic                isTarget,
  input logic                reqPulse,
  input logic                ackPulse,
  input logic                phaseChange,
  input logic [OFFSET_W-1:0] maxOffset,
  input logic                fifoWrite,
  input logic [LEVEL_W-1:0]  fifoLevel,
  input logic                xferStart,
  input logic [1:0]          xferType,
  input logic                clearErr,
  input logic                errFlag,
  input logic [2:0]          errCause,
  input logic [OFFSET_W-1:0] offsetCount
);

  localparam logic [LEVEL_W-1:0] FULL = LEVEL_W'(FIFO_DEPTH);

  AST_FLOOR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (offsetCount == '0 && !reqPulse) |=> offsetCount == '0); // R2

  AST_FIFO_OVF: assert property (@(posedge clk) disable iff (!rstN)
    (fifoWrite && fifoLevel == FULL) |=> errFlag); // R3

  AST_UNDERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    (isTarget && ackPulse && !reqPulse && offsetCount == '0 && maxOffset != '0)
    |=> errFlag); // R4

  AST_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    (reqPulse && !ackPulse && maxOffset != '0 && offsetCount >= maxOffset)
    |=> errFlag); // R5

  AST_PHASE: assert property (@(posedge clk) disable iff (!rstN)
    (!isTarget && phaseChange && maxOffset != '0 && offsetCount != '0)
    |=> errFlag); // R6

  AST_RESIDUAL: assert property (@(posedge clk) disable iff (!rstN)
    (xferStart && xferType != 2'b00 && fifoLevel != '0) |=> errFlag); // R7

  AST_ASYNC_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (maxOffset == '0) |=> offsetCount == '0); // R8

  AST_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (errFlag && !clearErr) |=> (errFlag && $stable(errCause))); // R9

  AST_CLEAR_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!errFlag) |-> (errCause == 3'd0)); // R10

endmodule

bind sync_offset_guard soed_checker #(
  .OFFSET_W  (OFFSET_W),
  .FIFO_DEPTH(FIFO_DEPTH),
  .LEVEL_W   (LEVEL_W)
) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .isTarget   (isTarget),
  .reqPulse   (reqPulse),
  .ackPulse   (ackPulse),
  .phaseChange(phaseChange),
  .maxOffset  (maxOffset),
  .fifoWrite  (fifoWrite),
  .fifoLevel  (fifoLevel),
  .xferStart  (xferStart),
  .xferType   (xferType),
  .clearErr   (clearErr),
  .errFlag    (errFlag),
  .errCause   (errCause),
  .offsetCount(offsetCount)
);

// File: tb/sync_offset_guard_tb_top.sv
module sync_offset_guard_tb_top;

  localparam int OW    = 4;
  localparam int DEPTH = 8;
  localparam int LW    = $clog2(DEPTH + 1);

  logic          clk = 1'b0;
  logic          rstN;
  logic          isTarget, reqPulse, ackPulse, phaseChange;
  logic [OW-1:0] maxOffset;
  logic          fifoWrite;
  logic [LW-1:0] fifoLevel;
  logic          xferStart;
  logic [1:0]    xferType;
  logic          clearErr;
  logic          errFlag;
  logic [2:0]    errCause;
  logic [OW-1:0] offsetCount;

  int errors = 0;
  int checks = 0;
  int refCnt = 0;
  int refFlag = 0;
  int refCause = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sync_offset_guard #(.OFFSET_W(OW), .FIFO_DEPTH(DEPTH)) dut_i (
    .clk(clk), .rstN(rstN), .isTarget(isTarget), .reqPulse(reqPulse),
    .ackPulse(ackPulse), .phaseChange(phaseChange), .maxOffset(maxOffset),
    .fifoWrite(fifoWrite), .fifoLevel(fifoLevel), .xferStart(xferStart),
    .xferType(xferType), .clearErr(clearErr), .errFlag(errFlag),
    .errCause(errCause), .offsetCount(offsetCount)
  );

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Expected cause code for the present inputs, from the requirements.
  function automatic int expCause(int cnt);
    int mo = int'(maxOffset);
    bit sy = (mo != 0);
    if (fifoWrite && int'(fifoLevel) == DEPTH) return 1;                  // R3
    if (sy && isTarget && ackPulse && !reqPulse && cnt == 0) return 2;    // R4
    if (sy && reqPulse && !ackPulse && cnt >= mo) return 3;               // R5
    if (sy && !isTarget && phaseChange && cnt != 0) return 4;             // R6
    if (xferStart && xferType != 2'b00 && fifoLevel != 0) return 5;       // R7
    return 0;
  endfunction

  function automatic int expCount(int cnt);
    if (maxOffset == 0) return 0;                                         // R8
    if (reqPulse && !ackPulse) return (cnt == (1 << OW) - 1) ? cnt : cnt + 1;
    if (ackPulse && !reqPulse) return (cnt == 0) ? 0 : cnt - 1;
    return cnt;                                                           // R1
  endfunction

  task automatic idle();
    reqPulse = 0; ackPulse = 0; phaseChange = 0; fifoWrite = 0;
    fifoLevel = '0; xferStart = 0; xferType = 2'b00; clearErr = 0;
  endtask

  task automatic step(string tag);
    int c  = expCause(refCnt);
    int nc = expCount(refCnt);
    int nf = refFlag;
    int nk = refCause;
    if (c != 0 && (refFlag == 0 || clearErr)) begin nf = 1; nk = c; end   // R9
    else if (clearErr) begin nf = 0; nk = 0; end                          // R10
    @(posedge clk);
    @(negedge clk);
    check(tag, "offsetCount", int'(offsetCount), nc);
    check(tag, "errFlag", int'(errFlag), nf);
    check(tag, "errCause", int'(errCause), nk);
    refCnt = nc; refFlag = nf; refCause = nk;
    idle();
  endtask

  task automatic clr();
    clearErr = 1;
    step("R10 clear");
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0c1a));
    idle(); isTarget = 0; maxOffset = 4; rstN = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1;
    check("R11", "offsetCount", int'(offsetCount), 0);
    check("R11", "errFlag", int'(errFlag), 0);
    check("R11", "errCause", int'(errCause), 0);

    // R1: counting
    repeat (3) begin reqPulse = 1; step("R1 req"); end
    reqPulse = 1; ackPulse = 1; step("R1 both");
    ackPulse = 1; step("R1 ack");
    // R5: overflow at max 4
    repeat (2) begin reqPulse = 1; step("R5 fill"); end
    reqPulse = 1; step("R5 overflow");
    clr();
    // R6: phase change, both roles
    isTarget = 1; phaseChange = 1; step("R6 target none");
    isTarget = 0; phaseChange = 1; step("R6 initiator");
    clr();
    // R2 floor and R4 underflow
    repeat (6) begin ackPulse = 1; step("R2 drain"); end
    ackPulse = 1; step("R4 initiator none");
    isTarget = 1; ackPulse = 1; step("R4 target");
    clr(); isTarget = 0;
    // R3 data overflow
    fifoWrite = 1; fifoLevel = LW'(DEPTH - 1); step("R3 not full");
    fifoWrite = 1; fifoLevel = LW'(DEPTH); step("R3 full");
    clr();
    // R7 residual
    xferStart = 1; xferType = 2'b00; fifoLevel = 3; step("R7 sync rx");
    xferStart = 1; xferType = 2'b10; fifoLevel = 0; step("R7 empty");
    xferStart = 1; xferType = 2'b01; fifoLevel = 3; step("R7 residual");
    // R9: held through later violations
    fifoWrite = 1; fifoLevel = LW'(DEPTH); step("R9 later");
    clr();
    fifoWrite = 1; xferStart = 1; xferType = 2'b11; fifoLevel = LW'(DEPTH);
    step("R9 priority");
    // R10: clear with simultaneous violation
    clearErr = 1; xferStart = 1; xferType = 2'b01; fifoLevel = 2;
    step("R10 capture");
    clr();
    // R8 asynchronous
    reqPulse = 1; step("R8 prep");
    maxOffset = 0; step("R8 zero");
    isTarget = 1; ackPulse = 1; step("R8 no underflow");
    reqPulse = 1; step("R8 no overflow");
    isTarget = 0;
    // R2 ceiling with max 15
    maxOffset = 15;
    repeat (15) begin reqPulse = 1; step("R2 climb"); end
    reqPulse = 1; step("R2 ceiling");
    clr();
    repeat (15) begin ackPulse = 1; step("R2 descend"); end

    // Random mix
    for (int n = 0; n < 2000; n++) begin
      isTarget    = $urandom % 2;
      reqPulse    = ($urandom % 3) == 0;
      ackPulse    = ($urandom % 3) == 0;
      phaseChange = ($urandom % 16) == 0;
      fifoWrite   = ($urandom % 4) == 0;
      case ($urandom % 4)
        0: fifoLevel = '0;
        1: fifoLevel = LW'(DEPTH);
        default: fifoLevel = LW'($urandom % (DEPTH + 1));
      endcase
      xferStart = ($urandom % 16) == 0;
      xferType  = 2'($urandom);
      clearErr  = ($urandom % 6) == 0;
      if (($urandom % 64) == 0) maxOffset = OW'($urandom % 16);
      step("random R1 R9");
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule